// File: doc/BRIEF.md
# Pointer-Register Serial Bus Slave with Alert Response

This block is a two-wire serial bus (SMBus/I2C) slave for a monitoring chip. Its 7-bit bus address has the fixed upper nibble 0101. A 3-bit strap supplies the three low bits, and the strap is captured once after reset. The block keeps an 8-bit pointer. It turns bus transfers into single-byte accesses on a plain register port that a register file outside the block serves. It never stretches the clock and never auto-increments the pointer.

In a write transfer, the first byte after the address always loads the pointer. A second byte, if one is sent, is written to the register that the pointer selects. A read transfer returns the register at the stored pointer, so a read can follow an earlier pointer-only write with no new pointer write. The block also answers the SMBus Alert Response Address (0001100, read) for its interrupt line. When it is pending and enabled, it returns its own address with open-drain arbitration. It pulses an interrupt-clear output only when it wins that arbitration.

The bus inputs are expected to be already synchronized to `clk_i`. The block drives SDA only through a pull-low enable.

Top module: `smb_ptr_slave`

## Requirements
- R1: The slave address is {0101, strap}. The strap is captured in the first cycle after reset, and later strap changes have no effect on which address is acknowledged.
- R2: A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high. STOP releases SDA. A repeated START restarts address decoding from any point of a transfer.
- R3: The slave holds SDA low for the ninth clock after an address byte whose upper 7 bits match its address. It never pulls SDA for a non-matching address. SDA drive changes only while SCL is low.
- R4: In a write (R/W bit = 0), the first byte after the address is acknowledged and loads the pointer, which appears on `reg_addr_o`.
- R5: A second write byte is acknowledged and produces exactly one `reg_we_o` pulse, with that byte on `reg_wdata_o` and the pointer on `reg_addr_o`.
- R6: Write bytes after the second are not acknowledged and cause no register write.
- R7: In a read (R/W bit = 1), the slave pulses `reg_re_o` and sends the register at the stored pointer, MSB first. The pointer is unchanged, and SDA is released after that byte.
- R8: When `int_pend_i` = 1 and `ara_dis_i` = 0, the slave acknowledges address 0001100 with R/W = 1. It then sends the byte {own 7-bit address, 0}, MSB first.
- R9: The alert response address is not acknowledged when `int_pend_i` = 0 or `ara_dis_i` = 1.
- R10: A slave that sends its whole alert response byte without losing arbitration pulses `int_clr_o` for exactly one cycle.
- R11: If the slave releases SDA for a 1 bit and samples 0 on the SCL rise, it loses arbitration. It then stops driving for the rest of the byte and does not pulse `int_clr_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data |
| strap_i | input | 3 | Low address bits, captured once after reset |
| int_pend_i | input | 1 | Interrupt line is asserted |
| ara_dis_i | input | 1 | Configuration bit that disables the alert response |
| reg_rdata_i | input | 8 | Read data of the register at `reg_addr_o` |
| sda_pull_o | output | 1 | Pull SDA low when 1 |
| reg_addr_o | output | 8 | Pointer register |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_re_o | output | 1 | One-cycle strobe when read data is captured |
| int_clr_o | output | 1 | One-cycle interrupt clear after a won alert response |

## Verification
On every cycle, the assertions check several rules. SDA drive holds steady while SCL is high, except for the release that follows a START or STOP. Both STOP and START release the line. The write strobe and the interrupt clear are single-cycle pulses. The bench scenarios cover what needs whole transfers to show: address matching against the captured strap, the pointer-then-data write order, the NACK of a third write byte, reads from a stored pointer, repeated START in the middle of a byte, and the alert response in its enabled, disabled, won and lost cases against a simulated competing slave.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_SKIP
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_PTR,
    PH_DATA
  } smb_phase_e;
endpackage

// File: rtl/smb_bus_cond.sv
module smb_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/smb_shreg.sv
module smb_shreg #(
  parameter int W     = 8,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [W-1:0]     data_o,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      cnt_o  <= '0;
    end else if (clr_i) begin
      cnt_o  <= '0;
    end else if (shift_i) begin
      data_o <= {data_o[W-2:0], bit_i};
      cnt_o  <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/smb_ptr_slave.sv
module smb_ptr_slave
  import smb_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         STRAP_W  = 3,
  parameter logic [3:0] FIXED_HI = 4'b0101,
  parameter logic [6:0] ARA_ADDR = 7'b0001100
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               int_pend_i,
  input  logic               ara_dis_i,
  input  logic [DATA_W-1:0]  reg_rdata_i,
  output logic               sda_pull_o,
  output logic [DATA_W-1:0]  reg_addr_o,
  output logic [DATA_W-1:0]  reg_wdata_o,
  output logic               reg_we_o,
  output logic               reg_re_o,
  output logic               int_clr_o
);
  localparam int CNT_W  = $clog2(DATA_W + 1);
  localparam int ADDR_W = DATA_W - 1;

  logic scl_rise, scl_fall, start_det, stop_det;
  logic [DATA_W-1:0] rx_byte, tx_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [STRAP_W-1:0] strap_q;
  logic strap_ok, is_ara, is_rd;
  smb_state_e state;
  smb_phase_e phase;
  logic [ADDR_W-1:0] own_addr;
  logic byte_end, own_hit, ara_hit, sh_clr, sh_en;

  smb_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  assign sh_clr = start_det | (state == ST_ACK && scl_fall);
  assign sh_en  = scl_rise & (state == ST_RX || state == ST_TX);

  smb_shreg #(.W(DATA_W), .CNT_W(CNT_W)) u_sh (
    .clk_i, .rst_ni, .clr_i(sh_clr), .shift_i(sh_en), .bit_i(sda_i),
    .data_o(rx_byte), .cnt_o(bit_cnt)
  );

  assign own_addr = {FIXED_HI, strap_q};
  assign byte_end = scl_fall && (bit_cnt == CNT_W'(DATA_W));
  assign own_hit  = rx_byte[DATA_W-1:1] == own_addr;
  assign ara_hit  = rx_byte == {ARA_ADDR, 1'b1} && int_pend_i && !ara_dis_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state       <= ST_IDLE;
      phase       <= PH_ADDR;
      sda_pull_o  <= 1'b0;
      reg_addr_o  <= '0;
      reg_wdata_o <= '0;
      reg_we_o    <= 1'b0;
      reg_re_o    <= 1'b0;
      int_clr_o   <= 1'b0;
      is_ara      <= 1'b0;
      is_rd       <= 1'b0;
      tx_q        <= '0;
      strap_q     <= '0;
      strap_ok    <= 1'b0;
    end else begin
      reg_we_o  <= 1'b0;
      reg_re_o  <= 1'b0;
      int_clr_o <= 1'b0;
      if (!strap_ok) begin
        strap_q  <= strap_i;
        strap_ok <= 1'b1;
      end
      if (start_det) begin
        state      <= ST_RX;
        phase      <= PH_ADDR;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: if (byte_end) begin
            unique case (phase)
              PH_ADDR: begin
                if (own_hit) begin
                  is_ara <= 1'b0; is_rd <= rx_byte[0];
                  state <= ST_ACK; sda_pull_o <= 1'b1;
                end else if (ara_hit) begin
                  is_ara <= 1'b1; is_rd <= 1'b1;
                  state <= ST_ACK; sda_pull_o <= 1'b1;
                end else begin
                  state <= ST_SKIP;
                end
              end
              PH_PTR: begin
                reg_addr_o <= rx_byte;
                state <= ST_ACK; sda_pull_o <= 1'b1;
              end
              default: begin
                reg_wdata_o <= rx_byte;
                reg_we_o    <= 1'b1;
                state <= ST_ACK; sda_pull_o <= 1'b1;
              end
            endcase
          end
          ST_ACK: if (scl_fall) begin
            sda_pull_o <= 1'b0;
            if (is_rd) begin
              state <= ST_TX;
              if (is_ara) begin
                tx_q       <= {own_addr, 1'b0};
                sda_pull_o <= ~own_addr[ADDR_W-1];
              end else begin
                tx_q       <= reg_rdata_i;
                reg_re_o   <= 1'b1;
                sda_pull_o <= ~reg_rdata_i[DATA_W-1];
              end
            end else if (phase == PH_ADDR) begin
              phase <= PH_PTR; state <= ST_RX;
            end else if (phase == PH_PTR) begin
              phase <= PH_DATA; state <= ST_RX;
            end else begin
              state <= ST_SKIP;
            end
          end
          ST_TX: begin
            if (scl_rise && is_ara && tx_q[DATA_W-1] && !sda_i) begin
              // lost arbitration: leave the bus, keep interrupt pending
              state      <= ST_SKIP;
              sda_pull_o <= 1'b0;
            end else if (byte_end) begin
              sda_pull_o <= 1'b0;
              int_clr_o  <= is_ara;
              state      <= ST_SKIP;
            end else if (scl_fall) begin
              tx_q       <= {tx_q[DATA_W-2:0], 1'b0};
              sda_pull_o <= ~tx_q[DATA_W-2];
            end
          end
          default: ;
        endcase
      end
    end
  end

  a_r2_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_pull_o);
  a_r2_start_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> !sda_pull_o);
  a_r3_steady_scl_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && !$past(start_det) && !$past(stop_det))
      |-> $stable(sda_pull_o));
  a_r5_we_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  a_r10_clr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> !int_clr_o);
endmodule

// File: tb/smb_ptr_slave_test.sv
`timescale 1ns/1ps
module smb_ptr_slave_test;
  localparam int HALF = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl = 1'b1, m_sda = 1'b1, comp_pull = 1'b0;
  logic [2:0] strap = 3'b101;
  logic int_pend = 1'b0, ara_dis = 1'b0;
  logic sda_pull, we, re, iclr, sda_bus;
  logic [7:0] raddr, wdata, rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int total = 0, bad = 0, we_cnt = 0, clr_cnt = 0, re_cnt = 0;
  logic pull_mid, done = 1'b0;

  assign sda_bus = m_sda & ~sda_pull & ~comp_pull;
  assign rdata = mem[raddr];

  smb_ptr_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .strap_i(strap), .int_pend_i(int_pend), .ara_dis_i(ara_dis),
    .reg_rdata_i(rdata), .sda_pull_o(sda_pull), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re), .int_clr_o(iclr)
  );

  always @(posedge clk) begin
    if (we) begin mem[raddr] <= wdata; we_cnt <= we_cnt + 1; end
    if (iclr) clr_cnt <= clr_cnt + 1;
    if (re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic hp(); repeat (HALF) @(negedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; hp(); m_scl = 1'b1; hp(); m_sda = 1'b0; hp(); m_scl = 1'b0;
  endtask
  task automatic bus_stop();
    m_sda = 1'b0; hp(); m_scl = 1'b1; hp(); m_sda = 1'b1; hp();
  endtask
  task automatic bit_xfer(input logic b, input logic cb, output logic r);
    m_sda = b; comp_pull = ~cb; hp();
    m_scl = 1'b1; repeat (HALF/2) @(negedge clk);
    r = sda_bus; pull_mid = sda_pull;
    repeat (HALF/2) @(negedge clk); m_scl = 1'b0;
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_xfer(b[i], 1'b1, r);
    bit_xfer(1'b1, 1'b1, r); ack = ~r;
  endtask
  task automatic recv_byte(input logic [7:0] comp, output logic [7:0] d, output logic late);
    logic r;
    late = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, comp[i], r); d[i] = r;
      if (i <= 3 && pull_mid) late = 1'b1;
    end
    bit_xfer(1'b1, 1'b1, r);
  endtask

  function automatic logic [6:0] own(input logic [2:0] s); return {4'b0101, s}; endfunction

  task automatic wr_reg(input logic [6:0] a, input logic [7:0] p, input logic [7:0] d,
                        output logic a0, output logic a1, output logic a2);
    bus_start(); send_byte({a, 1'b0}, a0); send_byte(p, a1); send_byte(d, a2); bus_stop();
  endtask
  task automatic set_ptr(input logic [6:0] a, input logic [7:0] p, output logic a1);
    logic a0;
    bus_start(); send_byte({a, 1'b0}, a0); send_byte(p, a1); bus_stop();
  endtask
  task automatic rd_reg(input logic [6:0] a, output logic ack, output logic [7:0] d);
    logic late;
    bus_start(); send_byte({a, 1'b1}, ack); recv_byte(8'hFF, d, late); bus_stop();
  endtask

  initial begin
    logic a0, a1, a2, late, r;
    logic [7:0] d, p, v;
    int n;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 7 + 3); exp_mem[i] = 8'(i * 7 + 3); end
    repeat (4) @(negedge clk); rst_n = 1'b1; repeat (4) @(negedge clk);
    chk(!sda_pull && !we && !iclr && raddr == 0, "R3 reset idle", {sda_pull, we, iclr}, 0);
    strap = 3'b010;  // must not change the captured address
    // R1
    set_ptr(own(3'b010), 8'h10, a1);
    chk(!a1, "R1 late strap ignored", a1, 0);
    chk(raddr == 0, "R1 pointer untouched", raddr, 0);
    // R3/R4/R5
    n = we_cnt;
    wr_reg(own(3'b101), 8'h3C, 8'hA5, a0, a1, a2);
    chk(a0, "R3 address ack", a0, 1);
    chk(a1 && raddr == 8'h3C, "R4 pointer load", raddr, 8'h3C);
    chk(a2 && we_cnt == n + 1, "R5 one write", we_cnt - n, 1);
    exp_mem[8'h3C] = 8'hA5;
    chk(mem[8'h3C] == exp_mem[8'h3C], "R5 write data", mem[8'h3C], exp_mem[8'h3C]);
    // R7
    set_ptr(own(3'b101), 8'h3C, a1);
    n = re_cnt;
    rd_reg(own(3'b101), a0, d);
    chk(a0 && d == 8'hA5, "R7 read at pointer", d, 8'hA5);
    chk(re_cnt == n + 1 && raddr == 8'h3C, "R7 pointer kept", raddr, 8'h3C);
    chk(!sda_pull, "R7 released", sda_pull, 0);
    rd_reg(own(3'b101), a0, d);
    chk(d == 8'hA5, "R7 reread without pointer write", d, 8'hA5);
    // R6
    n = we_cnt;
    bus_start(); send_byte({own(3'b101), 1'b0}, a0); send_byte(8'h40, a1);
    send_byte(8'h11, a2); send_byte(8'h22, late); bus_stop();
    exp_mem[8'h40] = 8'h11;
    chk(!late, "R6 third byte nack", late, 0);
    chk(we_cnt == n + 1 && mem[8'h40] == exp_mem[8'h40], "R6 no extra write", mem[8'h40], exp_mem[8'h40]);
    // R3 mismatch
    bus_start(); send_byte({7'h2C, 1'b1}, a0); bus_stop();
    chk(!a0, "R3 foreign address nack", a0, 0);
    // R2 repeated start after pointer byte, then read
    bus_start(); send_byte({own(3'b101), 1'b0}, a0); send_byte(8'h40, a1);
    bus_start(); send_byte({own(3'b101), 1'b1}, a0); recv_byte(8'hFF, d, late); bus_stop();
    chk(a0 && d == exp_mem[8'h40], "R2 repeated start read", d, exp_mem[8'h40]);
    // R2 restart inside address byte
    bus_start(); bit_xfer(1'b0, 1'b1, r); bit_xfer(1'b1, 1'b1, r); bit_xfer(1'b1, 1'b1, r);
    bus_start(); send_byte({own(3'b101), 1'b1}, a0); recv_byte(8'hFF, d, late); bus_stop();
    chk(a0 && d == exp_mem[8'h40], "R2 restart mid byte", d, exp_mem[8'h40]);
    // R9
    int_pend = 1'b0;
    bus_start(); send_byte(8'h19, a0); bus_stop();
    chk(!a0, "R9 no pending nack", a0, 0);
    int_pend = 1'b1; ara_dis = 1'b1;
    bus_start(); send_byte(8'h19, a0); bus_stop();
    chk(!a0, "R9 disabled nack", a0, 0);
    // R8/R10
    ara_dis = 1'b0; n = clr_cnt;
    bus_start(); send_byte(8'h19, a0); recv_byte(8'hFF, d, late); bus_stop();
    chk(a0, "R8 alert ack", a0, 1);
    chk(d == {own(3'b101), 1'b0}, "R8 alert address", d, {own(3'b101), 1'b0});
    chk(clr_cnt == n + 1, "R10 single clear", clr_cnt - n, 1);
    // R11 competitor 0101001 wins
    n = clr_cnt;
    bus_start(); send_byte(8'h19, a0); recv_byte({own(3'b001), 1'b0}, d, late); bus_stop();
    comp_pull = 1'b0;
    chk(d == {own(3'b001), 1'b0}, "R11 winner on bus", d, {own(3'b001), 1'b0});
    chk(!late, "R11 quiet after loss", late, 0);
    chk(clr_cnt == n, "R11 no clear", clr_cnt - n, 0);
    int_pend = 1'b0;
    // random traffic R4/R5/R7
    for (int k = 0; k < 24; k++) begin
      p = 8'($urandom); v = 8'($urandom);
      if (k % 3 == 0) begin p = (k % 2) ? 8'hFF : 8'h00; end
      wr_reg(own(3'b101), p, v, a0, a1, a2);
      exp_mem[p] = v;
      chk(a0 && a1 && a2, "R5 random write acks", {a0, a1, a2}, 7);
      set_ptr(own(3'b101), 8'($urandom), a1);
      set_ptr(own(3'b101), p, a1);
      chk(raddr == p, "R4 random pointer", raddr, p);
      rd_reg(own(3'b101), a0, d);
      chk(d == exp_mem[p], "R7 random read", d, exp_mem[p]);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule